// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Aliased Operand Register

This block holds two 8-bit signed operands in registers and multiplies them each time software writes either one. The multiplier forms radix-2 partial products, treats the sign row of the second operand as a subtraction (an inverted row plus a single correction bit), and reduces the rows with a chain of 3:2 carry-save stages ahead of one final carry-propagate adder. The 16-bit product is registered. Depending on which address performed the write, the product is also added into a 24-bit accumulator.

The first operand register is reachable at two write addresses. A write to its main address (or to the second operand register) multiplies and accumulates. A write to its alias address multiplies only, so a caller can form a stand-alone product without disturbing a running sum. Accumulation wraps modulo 2^24. A sticky flag records any signed overflow, which is detected when both addends have the same sign and the sum's sign differs from it. A write to a dedicated clear address zeroes the sum and the flag. The result registers, the operands and the flag are readable through a combinational read port. A one-cycle completion pulse marks each committed result.

Top module: `mac_unit`

## Requirements
- R1: After a synchronous reset every readable location returns zero and `done` is low.
- R2: A write to address 0 or address 2 loads operand A from `wr_data`, and a write to address 1 loads operand B. Reads at addresses 0 and 2 return A and address 1 returns B, each sign-extended to 24 bits.
- R3: When a write to address 0, 1 or 2 is sampled at clock edge k, the product register takes the signed product of the A and B contents after that write at edge k+1, and `done` is high for exactly the cycle that follows edge k+1. Address 4 reads the product sign-extended.
- R4: For writes to address 0 or 1, edge k+1 also adds the sign-extended product into the accumulator, modulo 2^24. Address 5 reads the accumulator. Nothing else changes the accumulator except a clear or a reset.
- R5: For a write to address 2, the product is updated but the accumulator keeps its value.
- R6: The overflow flag (bit 0 of address 6) is set when an accumulation adds two values of equal sign and obtains a result of the other sign. Once set it stays set until a clear or a reset.
- R7: A write to address 3 clears the accumulator and the flag at the edge that samples it and starts no multiply. If an accumulation commits at that same edge, the clear wins. The operands and the product are unchanged.
- R8: Writes to addresses 4 to 7 change no register and start no multiply.
- R9: Reads of addresses 3 and 7, and bits 23 to 1 of address 6, return zero.
- R10: The product is exact for every pair of 8-bit signed operands, including -128 x -128 = 16384 and -128 x 127 = -16256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 24 | Read data for `rd_addr`, combinational |
| done | output | 1 | One-cycle pulse when a product has been committed |

## Verification
A clear written in the cycle directly after an operand-B write lands on the same edge at which that write's accumulation commits. The bench provokes this with a main-address write, then a B write, then an immediate clear. It judges the result by reading back a zero accumulator and a zero flag while the product still shows the new value. The alias write and the clear likewise share an edge during the overflow setup. The cycle-level reference model, which applies the commit first and the clear second, flags any ordering error on the clock where it occurs.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  localparam int ADDR_W = 3;

  // write side: 0,1,2 start a multiply; 3 clears; 4..7 are ignored
  localparam logic [ADDR_W-1:0] ADR_A_MAIN  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_B       = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_A_ALIAS = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLR     = 3'd3;
  // read side
  localparam logic [ADDR_W-1:0] ADR_PROD    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_ACC     = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_STAT    = 3'd6;
endpackage

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
// Radix-2 signed array multiplier: W partial-product rows plus one
// correction row, reduced by a linear chain of 3:2 carry-save stages.
module mac_mult #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW   = 2 * W;
  localparam int ROWS = W + 1;

  logic [PW-1:0] ext_a;
  logic [PW-1:0] row [ROWS];
  logic [PW-1:0] sum_v [ROWS-1];
  logic [PW-1:0] cry_v [ROWS-1];

  assign ext_a = {{W{a[W-1]}}, a};

  genvar i;
  generate
    for (i = 0; i < W - 1; i++) begin : g_pos_rows
      assign row[i] = b[i] ? (ext_a << i) : '0;
    end
  endgenerate

  // sign bit of b weighs -2^(W-1): invert the shifted row and add 1 at its LSB
  assign row[W-1] = b[W-1] ? ((~ext_a) << (W - 1)) : '0;
  assign row[W]   = {{(PW-1){1'b0}}, b[W-1]} << (W - 1);

  assign sum_v[0] = row[0];
  assign cry_v[0] = row[1];

  genvar j;
  generate
    for (j = 0; j < ROWS - 2; j++) begin : g_csa
      assign sum_v[j+1] = sum_v[j] ^ cry_v[j] ^ row[j+2];
      assign cry_v[j+1] = ((sum_v[j] & cry_v[j]) |
                           (sum_v[j] & row[j+2]) |
                           (cry_v[j] & row[j+2])) << 1;
    end
  endgenerate

  assign p = sum_v[ROWS-2] + cry_v[ROWS-2];
endmodule

// File: rtl/mac_ctrl.sv
`timescale 1ns/1ps
// Write decode, operand registers and the one-cycle commit request.
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [OP_W-1:0]   wr_data,
  output logic [OP_W-1:0]   a_q,
  output logic [OP_W-1:0]   b_q,
  output logic              op_fire,
  output logic              clr_fire,
  output logic              pend_q,
  output logic              pend_acc_q
);
  logic hit_a;
  logic hit_b;
  logic acc_req;

  always_comb begin
    hit_a    = wr_en && (wr_addr == ADR_A_MAIN || wr_addr == ADR_A_ALIAS);
    hit_b    = wr_en && (wr_addr == ADR_B);
    clr_fire = wr_en && (wr_addr == ADR_CLR);
    op_fire  = hit_a || hit_b;
    acc_req  = wr_en && (wr_addr == ADR_A_MAIN || wr_addr == ADR_B);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q        <= '0;
      b_q        <= '0;
      pend_q     <= 1'b0;
      pend_acc_q <= 1'b0;
    end else begin
      if (hit_a) a_q <= wr_data;
      if (hit_b) b_q <= wr_data;
      pend_q     <= op_fire;
      pend_acc_q <= acc_req;
    end
  end
endmodule

// File: rtl/mac_acc.sv
`timescale 1ns/1ps
// Product register, wrapping accumulator with sticky signed-overflow flag.
module mac_acc #(
  parameter int OP_W  = 8,
  parameter int ACC_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                commit,
  input  logic                commit_acc,
  input  logic                clr,
  input  logic [2*OP_W-1:0]   prod_in,
  output logic [2*OP_W-1:0]   prod_q,
  output logic [ACC_W-1:0]    acc_q,
  output logic                ovf_q,
  output logic                step_ovf,
  output logic                done
);
  localparam int PW = 2 * OP_W;

  // returns {overflow, wrapped sum}; ACC_W must exceed PW
  function automatic logic [ACC_W:0] acc_add(input logic [ACC_W-1:0] acc,
                                             input logic [PW-1:0] prod);
    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] s;
    logic             ov;
    ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
    s   = acc + ext;
    ov  = (acc[ACC_W-1] == ext[ACC_W-1]) && (s[ACC_W-1] != acc[ACC_W-1]);
    return {ov, s};
  endfunction

  logic [ACC_W:0]   step;
  logic [ACC_W-1:0] step_sum;

  assign step     = acc_add(acc_q, prod_in);
  assign step_sum = step[ACC_W-1:0];
  assign step_ovf = step[ACC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      acc_q  <= '0;
      ovf_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= commit;
      if (commit) prod_q <= prod_in;
      if (clr) begin
        acc_q <= '0;
        ovf_q <= 1'b0;
      end else if (commit && commit_acc) begin
        acc_q <= step_sum;
        ovf_q <= ovf_q | step_ovf;
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
`timescale 1ns/1ps
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int ACC_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [OP_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ACC_W-1:0]  rd_data,
  output logic              done
);
  localparam int PW = 2 * OP_W;

  logic [OP_W-1:0]  a_q;
  logic [OP_W-1:0]  b_q;
  logic             op_fire;
  logic             clr_fire;
  logic             commit_fire;
  logic             commit_acc;
  logic [PW-1:0]    prod_comb;
  logic [PW-1:0]    prod_q;
  logic [ACC_W-1:0] acc_q;
  logic             ovf_q;
  logic             step_ovf;

  mac_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .a_q        (a_q),
    .b_q        (b_q),
    .op_fire    (op_fire),
    .clr_fire   (clr_fire),
    .pend_q     (commit_fire),
    .pend_acc_q (commit_acc)
  );

  mac_mult #(.W(OP_W)) u_mult (
    .a (a_q),
    .b (b_q),
    .p (prod_comb)
  );

  mac_acc #(.OP_W(OP_W), .ACC_W(ACC_W)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit_fire),
    .commit_acc (commit_acc),
    .clr        (clr_fire),
    .prod_in    (prod_comb),
    .prod_q     (prod_q),
    .acc_q      (acc_q),
    .ovf_q      (ovf_q),
    .step_ovf   (step_ovf),
    .done       (done)
  );

  always_comb begin
    unique case (rd_addr)
      ADR_A_MAIN, ADR_A_ALIAS: rd_data = {{(ACC_W-OP_W){a_q[OP_W-1]}}, a_q};
      ADR_B:                   rd_data = {{(ACC_W-OP_W){b_q[OP_W-1]}}, b_q};
      ADR_PROD:                rd_data = {{(ACC_W-PW){prod_q[PW-1]}}, prod_q};
      ADR_ACC:                 rd_data = acc_q;
      ADR_STAT:                rd_data = {{(ACC_W-1){1'b0}}, ovf_q};
      default:                 rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mac_unit_chk.sv
`timescale 1ns/1ps
module mac_unit_chk
  import mac_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int ACC_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done,
  input logic              op_fire,
  input logic              commit,
  input logic              commit_acc,
  input logic              clr,
  input logic [OP_W-1:0]   a_q,
  input logic [ACC_W-1:0]  acc_q,
  input logic              ovf_q
);
  assert_commit_after_write_R3: assert property (@(posedge clk) disable iff (rst)
    op_fire |=> commit);

  assert_done_after_commit_R3: assert property (@(posedge clk) disable iff (rst)
    commit |=> done);

  assert_done_needs_commit_R3: assert property (@(posedge clk) disable iff (rst)
    !commit |=> !done);

  assert_acc_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!commit && !clr) |=> $stable(acc_q));

  assert_alias_keeps_acc_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && !commit_acc && !clr) |=> $stable(acc_q));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr) |=> ovf_q);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0 && !ovf_q));

  assert_ignored_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[ADDR_W-1]) |=> (!commit && $stable(a_q)));
endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .done       (done),
  .op_fire    (op_fire),
  .commit     (commit_fire),
  .commit_acc (commit_acc),
  .clr        (clr_fire),
  .a_q        (a_q),
  .acc_q      (acc_q),
  .ovf_q      (ovf_q)
);

// File: tb/tb_mac_unit.sv
`timescale 1ns/100ps
module tb_mac_unit;
  localparam int OPW  = 8;
  localparam int ACCW = 24;
  localparam int AMAX = 8388607;
  localparam int AMIN = -8388608;

  logic            clk = 1'b0;
  logic            rst;
  logic            wr_en;
  logic [2:0]      wr_addr;
  logic [OPW-1:0]  wr_data;
  logic [2:0]      rd_addr;
  logic [ACCW-1:0] rd_data;
  logic            done;

  always #2.5 clk = ~clk;

  mac_unit #(.OP_W(OPW), .ACC_W(ACCW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state
  int ma, mb, mprod, macc;
  bit movf, mdone, mpend, mpacc;

  task automatic check(input string req, input logic [ACCW-1:0] act,
                       input logic [ACCW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int wrap_acc(input int v);
    int r;
    r = v;
    if (r > AMAX) r = r - (1 << ACCW);
    if (r < AMIN) r = r + (1 << ACCW);
    return r;
  endfunction

  function automatic logic [ACCW-1:0] model_read(input int k);
    case (k)
      0, 2:    return ACCW'(ma);
      1:       return ACCW'(mb);
      4:       return ACCW'(mprod);
      5:       return ACCW'(macc);
      6:       return {{(ACCW-1){1'b0}}, movf};
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input int k);
    case (k)
      0, 1, 2: return "R2 operand read";
      4:       return "R3 R10 product";
      5:       return "R4 accumulator";
      6:       return "R6 status";
      default: return "R9 zero read";
    endcase
  endfunction

  // reference model, then compare every readable location once per clock
  always @(posedge clk) begin
    int s;
    if (rst) begin
      ma = 0; mb = 0; mprod = 0; macc = 0;
      movf = 0; mdone = 0; mpend = 0; mpacc = 0;
    end else begin
      if (mpend) begin
        mprod = ma * mb;
        if (mpacc) begin
          s = macc + mprod;
          if (s > AMAX || s < AMIN) movf = 1;
          macc = wrap_acc(s);
        end
        mdone = 1;
      end else begin
        mdone = 0;
      end
      if (wr_en && wr_addr == 3) begin
        macc = 0;
        movf = 0;
      end
      if (wr_en && (wr_addr == 0 || wr_addr == 2)) ma = int'($signed(wr_data));
      if (wr_en && wr_addr == 1) mb = int'($signed(wr_data));
      mpend = wr_en && (wr_addr <= 2);
      mpacc = wr_en && (wr_addr == 0 || wr_addr == 1);
    end
    #1;
    if (!rst) begin
      for (int k = 0; k < 8; k++) begin
        rd_addr = 3'(k);
        #0.1;
        check(req_of(k), rd_data, model_read(k));
      end
      check("R3 done pulse", {{(ACCW-1){1'b0}}, done}, {{(ACCW-1){1'b0}}, mdone});
    end
  end

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d[OPW-1:0];
    @(posedge clk);
    #0.3;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [ACCW-1:0] v);
    @(negedge clk);
    #0.5;
    rd_addr = a;
    #0.2;
    v = rd_data;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [ACCW-1:0] v;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: everything reads zero after reset
    for (int k = 0; k < 8; k++) begin
      rd(3'(k), v);
      check("R1 reset read", v, '0);
    end
    check("R1 reset done", {{(ACCW-1){1'b0}}, done}, '0);

    // R3 R4: main-address write then B write
    wr(0, 7);
    wr(1, -3);
    idle(2);
    rd(4, v); check("R3 product 7*-3", v, ACCW'(-21));
    rd(5, v); check("R4 accumulated", v, ACCW'(-21));

    // R5: alias write forms a product only
    wr(2, -4);
    idle(2);
    rd(4, v); check("R5 alias product", v, ACCW'(12));
    rd(5, v); check("R5 alias keeps accumulator", v, ACCW'(-21));

    // R8: writes to 4..7 are ignored
    wr(4, 9); wr(5, 9); wr(6, 9); wr(7, 9);
    idle(2);
    rd(0, v); check("R8 A unchanged", v, ACCW'(-4));
    rd(1, v); check("R8 B unchanged", v, ACCW'(-3));
    rd(4, v); check("R8 product unchanged", v, ACCW'(12));
    rd(5, v); check("R8 accumulator unchanged", v, ACCW'(-21));

    // R7: clear lands on the same edge as a commit
    wr(0, 5);
    wr(1, 3);
    wr(3, 0);
    idle(2);
    rd(5, v); check("R7 clear wins accumulator", v, '0);
    rd(6, v); check("R7 clear wins flag", v, '0);
    rd(4, v); check("R7 product kept", v, ACCW'(15));
    rd(0, v); check("R7 A kept", v, ACCW'(5));

    // R6: drive the accumulator past its positive limit
    wr(1, -128);
    wr(2, -128);
    wr(3, 0);
    for (int n = 0; n < 512; n++) wr(1, -128);
    idle(2);
    rd(6, v); check("R6 overflow set", v, ACCW'(1));
    rd(5, v); check("R6 wrapped sum", v, 24'h800000);
    wr(0, -1);
    idle(2);
    rd(6, v); check("R6 overflow sticky", v, ACCW'(1));
    rd(5, v); check("R6 sum after sticky add", v, 24'h800080);
    wr(3, 0);
    idle(2);
    rd(6, v); check("R7 clear drops flag", v, '0);

    // R10: every operand pair, compared by the per-clock model
    for (int a = -128; a < 128; a++) begin
      wr(2, a);
      for (int b = -128; b < 128; b++) wr(1, b);
    end
    wr(2, -128); wr(1, -128);
    idle(2);
    rd(4, v); check("R10 -128*-128", v, ACCW'(16384));
    wr(1, 127);
    idle(2);
    rd(4, v); check("R10 -128*127", v, ACCW'(-16256));
    wr(2, 127);
    idle(2);
    rd(4, v); check("R10 127*127", v, ACCW'(16129));

    idle(3);
    summary();
    $finish;
  end
endmodule